// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block drains up to sixteen transmit rings kept in host memory and turns each frame descriptor into one contiguous byte stream. For each queue the host programs a ring base (address bits 35:8, so every ring starts on a 256-byte boundary) and advances a write index as it posts descriptors. The engine keeps the matching read index. Each ring has 256 slots of 128 bytes, and a queue with equal indices is empty.

A descriptor names up to twenty scattered buffers, each with a 36-bit byte address and a 12-bit length. The engine reads the descriptor through a single-outstanding request/response memory port. It first walks all the entries to add up the frame length, then walks them again and reads each buffer word by word. The buffer bytes go out one per beat on a valid/ready stream, with a last flag on the final byte and the queue number alongside. Queues take turns in round-robin order. A descriptor with too many entries or an oversized frame is dropped, and a sticky error flag is raised.

Top module: `txd_gather`

## Requirements
- R1: The descriptor at read index i of queue q is fetched from byte address {base,8'h00} + 128*i. Its entry count is byte 3 of the descriptor, bits 4:0 (bits 28:24 of the first little-endian word), and bits 7:5 of that byte are ignored.
- R2: Entry k starts at byte offset 4+6k of the descriptor. It holds a 32-bit low address (little-endian), then a 16-bit word whose bits 3:0 are address bits 35:32 and whose bits 15:4 are the buffer length in bytes.
- R3: Buffers are sent in entry order, one byte per beat, with nothing between them. The byte at address a is lane a[1:0] of the 32-bit word read at a with bits 1:0 cleared. Zero-length entries add no beats.
- R4: out_last is high on exactly the final byte of each frame, and out_qid gives the queue that the frame came from.
- R5: A queue whose write index equals its read index is empty and starts no memory reads. Up to 255 descriptors posted at once on one queue are all served.
- R6: After each descriptor (sent or skipped), the read index of its queue advances by one modulo 256. stat_rd shows the read index of queue stat_q.
- R7: A descriptor with an entry count above 20 is skipped without output and sets err_flag. err_flag stays high until reset.
- R8: A descriptor whose lengths sum to more than 8192 bytes is skipped without output and sets err_flag. A sum of exactly 8192 is sent.
- R9: A descriptor whose lengths sum to zero (including a count of zero) is skipped without output and does not set err_flag.
- R10: When a frame ends, the next queue served is the first non-empty one after it in ascending order, wrapping from 15 to 0. After reset the search starts at queue 0.
- R11: While out_valid is high and out_ready is low, out_data, out_last and out_qid stay unchanged.
- R12: A memory request stays valid with a stable, word-aligned address until it is accepted, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Ring base write strobe |
| base_q | input | 4 | Queue whose ring base is written |
| base_val | input | 28 | Ring base address bits 35:8 |
| wptr_we | input | 1 | Write index strobe |
| wptr_q | input | 4 | Queue whose write index is written |
| wptr_val | input | 8 | New write index |
| stat_q | input | 4 | Queue selected for stat_rd |
| stat_rd | output | 8 | Read index of the selected queue |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 36 | Word-aligned byte address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data, little-endian |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_qid | output | 4 | Queue of the current frame |
| err_flag | output | 1 | Sticky malformed-descriptor flag |

## Verification
The hardest state to reach is a ring holding 255 pending descriptors whose read index then wraps past zero. The bench gets there by holding out_ready low: the engine stalls in the first frame while 255 descriptors are written and the write index is posted in one step. It then releases the stream and posts ten more. Round-robin order is forced the same way, by stalling while three queues are loaded. The error flag is sticky, so the bench applies a reset between the oversize test and the entry-count test to show that each one raises the flag by itself.

// File: rtl/txd_gather.sv
module txd_gather #(
  parameter int NQ       = 16,
  parameter int IW       = 8,
  parameter int MAXBUF   = 20,
  parameter int MAXFRAME = 8192
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   base_we,
  input  logic [$clog2(NQ)-1:0]  base_q,
  input  logic [27:0]            base_val,
  input  logic                   wptr_we,
  input  logic [$clog2(NQ)-1:0]  wptr_q,
  input  logic [IW-1:0]          wptr_val,
  input  logic [$clog2(NQ)-1:0]  stat_q,
  output logic [IW-1:0]          stat_rd,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [35:0]            mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [31:0]            mem_rsp_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_last,
  output logic [$clog2(NQ)-1:0]  out_qid,
  output logic                   err_flag
);
  localparam int QW = $clog2(NQ);
  localparam int AW = 36;
  localparam int TW = $clog2(MAXBUF*4095 + 1);
  localparam int FW = $clog2(MAXFRAME + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_ENT0, S_ENT1, S_BRD, S_EMIT} st_t;

  logic [27:0]   base_r [NQ];
  logic [IW-1:0] rd_r   [NQ];
  logic [IW-1:0] wr_r   [NQ];
  st_t           state;
  logic          wait_rsp, pass, err;
  logic [QW-1:0] cq, rr_last, pick;
  logic          found;
  logic [4:0]    cnt, k;
  logic [31:0]   w0, word;
  logic [TW-1:0] total, tot_n;
  logic [FW-1:0] frem;
  logic [11:0]   brem;
  logic [AW-1:0] baddr, desc_base, ent_addr;
  logic [6:0]    k3;
  logic [5:0]    ent_w;
  logic [31:0]   ent_lo;
  logic [15:0]   ent_hl;
  logic          rsp, beat;

  assign rsp       = wait_rsp & mem_rsp_valid;
  assign beat      = out_valid & out_ready;
  assign desc_base = {base_r[cq], 8'h00} + AW'({rd_r[cq], 7'h00});
  assign k3        = 7'(k) * 7'd3;
  assign ent_w     = 6'(k3 >> 1) + 6'd1;
  assign ent_lo    = k[0] ? {mem_rsp_data[15:0], w0[31:16]} : w0;
  assign ent_hl    = k[0] ? mem_rsp_data[31:16] : mem_rsp_data[15:0];
  assign ent_addr  = {ent_hl[3:0], ent_lo};
  assign tot_n     = total + TW'(ent_hl[15:4]);

  assign stat_rd   = rd_r[stat_q];
  assign out_valid = (state == S_EMIT);
  assign out_data  = word[{baddr[1:0], 3'b000} +: 8];
  assign out_last  = (frem == FW'(1));
  assign out_qid   = cq;
  assign err_flag  = err;
  assign mem_req_valid = !wait_rsp && (state inside {S_HDR, S_ENT0, S_ENT1, S_BRD});

  always_comb begin
    case (state)
      S_ENT0:  mem_req_addr = desc_base + AW'({ent_w, 2'b00});
      S_ENT1:  mem_req_addr = desc_base + AW'({ent_w + 6'd1, 2'b00});
      S_BRD:   mem_req_addr = {baddr[AW-1:2], 2'b00};
      default: mem_req_addr = desc_base;
    endcase
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 1; i <= NQ; i++) begin
      int j;
      j = (int'(rr_last) + i) % NQ;
      if (!found && rd_r[j] != wr_r[j]) begin
        found = 1'b1;
        pick  = QW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        base_r[i] <= '0;
        rd_r[i]   <= '0;
        wr_r[i]   <= '0;
      end
      state <= S_IDLE; wait_rsp <= 1'b0; pass <= 1'b0; err <= 1'b0;
      cq <= '0; rr_last <= QW'(NQ-1); cnt <= '0; k <= '0;
      w0 <= '0; word <= '0; total <= '0; frem <= '0; brem <= '0; baddr <= '0;
    end else begin
      if (base_we) base_r[base_q] <= base_val;
      if (wptr_we) wr_r[wptr_q] <= wptr_val;
      if (mem_req_valid && mem_req_ready) wait_rsp <= 1'b1;
      else if (rsp) wait_rsp <= 1'b0;
      case (state)
        S_IDLE: if (found) begin
          cq <= pick; rr_last <= pick; state <= S_HDR;
        end
        S_HDR: if (rsp) begin
          cnt <= mem_rsp_data[28:24]; k <= '0; total <= '0; pass <= 1'b0;
          if (mem_rsp_data[28:24] > 5'(MAXBUF)) begin
            err <= 1'b1; rd_r[cq] <= rd_r[cq] + 1'b1; state <= S_IDLE;
          end else if (mem_rsp_data[28:24] == 5'd0) begin
            rd_r[cq] <= rd_r[cq] + 1'b1; state <= S_IDLE;
          end else state <= S_ENT0;
        end
        S_ENT0: if (rsp) begin
          w0 <= mem_rsp_data; state <= S_ENT1;
        end
        S_ENT1: if (rsp) begin
          if (!pass) begin
            total <= tot_n;
            if (k + 5'd1 == cnt) begin
              if (tot_n > TW'(MAXFRAME)) begin
                err <= 1'b1; rd_r[cq] <= rd_r[cq] + 1'b1; state <= S_IDLE;
              end else if (tot_n == '0) begin
                rd_r[cq] <= rd_r[cq] + 1'b1; state <= S_IDLE;
              end else begin
                pass <= 1'b1; k <= '0; frem <= FW'(tot_n); state <= S_ENT0;
              end
            end else begin
              k <= k + 5'd1; state <= S_ENT0;
            end
          end else if (ent_hl[15:4] == 12'd0) begin
            k <= k + 5'd1; state <= S_ENT0;
          end else begin
            baddr <= ent_addr; brem <= ent_hl[15:4]; state <= S_BRD;
          end
        end
        S_BRD: if (rsp) begin
          word <= mem_rsp_data; state <= S_EMIT;
        end
        S_EMIT: if (beat) begin
          frem  <= frem - 1'b1;
          brem  <= brem - 1'b1;
          baddr <= baddr + 1'b1;
          if (frem == FW'(1)) begin
            rd_r[cq] <= rd_r[cq] + 1'b1; state <= S_IDLE;
          end else if (brem == 12'd1) begin
            k <= k + 5'd1; state <= S_ENT0;
          end else if (baddr[1:0] == 2'b11) state <= S_BRD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_qid));

  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r12_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r4_last_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  a_r12_no_req_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

// File: tb/sim_txd_gather.sv
module sim_txd_gather;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 16;

  logic        clk, rst_n;
  logic        base_we, wptr_we;
  logic [3:0]  base_q, wptr_q, stat_q, out_qid;
  logic [27:0] base_val;
  logic [7:0]  wptr_val, stat_rd, out_data;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_rsp_data;
  logic        out_valid, out_ready, out_last, err_flag;

  txd_gather u0 (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_q(base_q), .base_val(base_val),
    .wptr_we(wptr_we), .wptr_q(wptr_q), .wptr_val(wptr_val),
    .stat_q(stat_q), .stat_rd(stat_rd),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_qid(out_qid), .err_flag(err_flag));

  logic [7:0]  mem [logic [35:0]];
  logic [8:0]  expq [NQ][$];
  int          frame_order[$];
  logic [7:0]  sw_wr [NQ];
  int          blen [32];
  logic [31:0] alloc;
  int          checks = 0, fails = 0;
  bit          hold = 0, done = 0;

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(logic [35:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [35:0] desc_addr(int q, logic [7:0] idx);
    return {28'hA00_0000 + 28'(q) * 28'h200, 8'h00} + 36'(idx) * 36'd128;
  endfunction

  // memory responder: one outstanding read, random ready and latency
  initial begin
    bit pend; int dly; logic [35:0] pa;
    pend = 0; dly = 0; pa = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0; mem_rsp_valid = 0; mem_req_ready = 0;
      end else begin
        if (mem_rsp_valid) mem_rsp_valid = 0;
        else if (pend && dly == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = {rdb(pa+3), rdb(pa+2), rdb(pa+1), rdb(pa)};
          pend = 0;
        end else if (pend) dly--;
        mem_req_ready = !pend && !mem_rsp_valid && ($urandom % 3 != 0);
        if (mem_req_ready && mem_req_valid) begin
          pend = 1; pa = mem_req_addr; dly = $urandom % 3;
        end
      end
    end
  end

  // stream sink and scoreboard
  initial begin
    bit stall; logic [7:0] pd; logic pl; logic [3:0] pq;
    stall = 0; pd = '0; pl = 0; pq = '0; out_ready = 0;
    forever begin
      @(negedge clk);
      if (stall && rst_n)
        chk(out_valid && out_data == pd && out_last == pl && out_qid == pq, "R11",
            "held beat changed", {out_valid, out_last, out_data}, {1'b1, pl, pd});
      out_ready = hold ? 1'b0 : ($urandom % 4 != 0);
      if (rst_n && out_valid && out_ready) begin
        if (expq[out_qid].size() == 0)
          chk(0, "R3", "unexpected beat on queue", out_qid, -1);
        else begin
          logic [8:0] e;
          e = expq[out_qid].pop_front();
          chk({out_last, out_data} == e, "R3/R4", "byte and last", {out_last, out_data}, e);
        end
        if (out_last) frame_order.push_back(int'(out_qid));
      end
      stall = rst_n && out_valid && !out_ready;
      pd = out_data; pl = out_last; pq = out_qid;
    end
  end

  task automatic set_bases();
    for (int q = 0; q < NQ; q++) begin
      @(negedge clk);
      base_we = 1; base_q = 4'(q); base_val = 28'hA00_0000 + 28'(q) * 28'h200;
    end
    @(negedge clk); base_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int q = 0; q < NQ; q++) begin sw_wr[q] = 0; expq[q].delete(); end
    set_bases();
  endtask

  task automatic post_desc(int q, int cnt);
    logic [35:0] d; int n; int total; int run; bit good;
    d = desc_addr(q, sw_wr[q]);
    for (int i = 0; i < 128; i++) mem[d + 36'(i)] = 8'($urandom);
    mem[d + 3] = {3'($urandom), 5'(cnt)};
    n = (cnt > 20) ? 20 : cnt;
    total = 0;
    for (int e = 0; e < n; e++) total += blen[e];
    good = (cnt <= 20) && (total <= 8192) && (total > 0);
    run = 0;
    for (int e = 0; e < n; e++) begin
      logic [3:0] hi; logic [31:0] lo; logic [35:0] ba, ea; logic [15:0] hl;
      hi = 4'($urandom); lo = alloc;
      alloc = alloc + 32'(blen[e]) + 32'd1 + 32'($urandom % 5);
      ba = {hi, lo}; hl = {12'(blen[e]), hi};
      ea = d + 36'(4 + 6*e);
      for (int b = 0; b < 4; b++) mem[ea + 36'(b)] = lo[8*b +: 8];
      mem[ea + 4] = hl[7:0]; mem[ea + 5] = hl[15:8];
      for (int b = 0; b < blen[e]; b++) begin
        logic [7:0] v;
        v = 8'($urandom);
        mem[ba + 36'(b)] = v;
        run++;
        if (good) expq[q].push_back({run == total, v});
      end
    end
    sw_wr[q] = sw_wr[q] + 8'd1;
  endtask

  task automatic kick(int q);
    @(negedge clk);
    wptr_we = 1; wptr_q = 4'(q); wptr_val = sw_wr[q];
    @(negedge clk); wptr_we = 0;
  endtask

  task automatic drain(int q, string req);
    stat_q = 4'(q);
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (stat_rd == sw_wr[q]) break;
    end
    repeat (4) @(negedge clk);
    chk(stat_rd == sw_wr[q], req, "read index after drain", stat_rd, sw_wr[q]);
    chk(expq[q].size() == 0, req, "bytes left undelivered", expq[q].size(), 0);
  endtask

  task automatic simple(int q, int cnt, int maxlen);
    for (int e = 0; e < 20; e++) blen[e] = 1 + $urandom % maxlen;
    post_desc(q, cnt);
  endtask

  initial begin
    void'($urandom(32'd2024));
    alloc = 32'h4000_0000;
    rst_n = 0; base_we = 0; wptr_we = 0; base_q = 0; wptr_q = 0;
    base_val = 0; wptr_val = 0; stat_q = 0;
    for (int q = 0; q < NQ; q++) sw_wr[q] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R5", "out_valid after reset", out_valid, 0);
    chk(mem_req_valid == 0, "R5", "mem_req_valid after reset", mem_req_valid, 0);
    chk(err_flag == 0, "R7", "err_flag after reset", err_flag, 0);
    chk(stat_rd == 0, "R6", "read index after reset", stat_rd, 0);
    set_bases();

    // R5: equal indices stay idle
    kick(1);
    repeat (20) @(negedge clk);
    chk(mem_req_valid == 0 && out_valid == 0, "R5", "empty queue started work", mem_req_valid, 0);

    // R10: round robin across queues 9, 2, 5
    frame_order.delete();
    hold = 1;
    simple(9, 2, 6); simple(9, 1, 6);
    simple(2, 3, 6); simple(2, 2, 6);
    simple(5, 1, 6); simple(5, 4, 6);
    kick(9); kick(2); kick(5);
    repeat (10) @(negedge clk);
    hold = 0;
    drain(9, "R10"); drain(2, "R10"); drain(5, "R10");
    begin
      int exp_ord[6] = '{9, 2, 5, 9, 2, 5};
      chk(frame_order.size() == 6, "R10", "frame count", frame_order.size(), 6);
      for (int i = 0; i < 6 && i < frame_order.size(); i++)
        chk(frame_order[i] == exp_ord[i], "R10", "service order", frame_order[i], exp_ord[i]);
    end

    // R2/R3: zero-length entries interleaved, odd and even entry slots
    blen[0] = 0; blen[1] = 7; blen[2] = 0; blen[3] = 3; blen[4] = 0;
    post_desc(4, 5); kick(4); drain(4, "R2");
    // R1/R2: full 20 entries
    simple(4, 20, 9); kick(4); drain(4, "R1");
    // R8: exactly 8192 bytes accepted
    blen[0] = 4092; blen[1] = 4092; blen[2] = 8;
    post_desc(6, 3); kick(6); drain(6, "R8");
    chk(err_flag == 0, "R8", "err_flag after 8192-byte frame", err_flag, 0);

    // R9: empty frames skipped silently
    post_desc(6, 0);
    blen[0] = 0; blen[1] = 0; blen[2] = 0;
    post_desc(6, 3);
    kick(6); drain(6, "R9");
    chk(err_flag == 0, "R9", "err_flag after empty frames", err_flag, 0);

    // R8: 8193 bytes skipped, then a good frame on the same queue
    blen[0] = 4092; blen[1] = 4092; blen[2] = 9;
    post_desc(6, 3);
    simple(6, 2, 5);
    kick(6); drain(6, "R8");
    chk(err_flag == 1, "R8", "err_flag after oversize frame", err_flag, 1);
    repeat (3) @(negedge clk);
    chk(err_flag == 1, "R7", "err_flag stays set", err_flag, 1);

    // R7: count above 20, checked from a fresh reset
    do_reset();
    chk(err_flag == 0, "R7", "err_flag cleared by reset", err_flag, 0);
    simple(3, 21, 4);
    simple(3, 31, 4);
    simple(3, 1, 4);
    kick(3); drain(3, "R7");
    chk(err_flag == 1, "R7", "err_flag after count 21", err_flag, 1);

    // R5/R6: 255 pending on one queue, then wrap past zero
    hold = 1;
    for (int i = 0; i < 255; i++) simple(7, 1, 2);
    kick(7);
    repeat (10) @(negedge clk);
    hold = 0;
    drain(7, "R5");
    chk(stat_rd == 8'd255, "R5", "index after 255 frames", stat_rd, 255);
    for (int i = 0; i < 10; i++) simple(7, 1, 3);
    kick(7); drain(7, "R6");
    chk(stat_rd == 8'd9, "R6", "index after wrap", stat_rd, 9);

    // random traffic
    for (int it = 0; it < 50; it++) begin
      int q; int nd;
      q = $urandom % NQ; nd = 1 + $urandom % 3;
      for (int d = 0; d < nd; d++) begin
        int c;
        c = ($urandom % 10 == 0) ? 21 + $urandom % 11 : $urandom % 9;
        for (int e = 0; e < 20; e++) blen[e] = ($urandom % 5 == 0) ? 0 : $urandom % 24;
        post_desc(q, c);
      end
      kick(q); drain(q, "R3");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule